// File: doc/BRIEF.md
# Fuse Array Read Sequencer

This block copies the contents of a one-time-programmable fuse array into a local byte buffer. After a start request it takes access to the fuse macro and drives the bank select to the configured bank. It then reads every physical address in turn, starting at zero and ending at `PHYS_SIZE-1`.

The fuse macro is accessed through a control-word style exchange. For each address the sequencer writes a control word that carries only the address field. The completion flag in that word is zero, and the zero flag is what launches the read. The sequencer then samples the readback flag once per poll interval. When the flag reads 1, the low data byte of the readback is written into the buffer at that address and the next address is launched. If the flag stays clear for `TIMEOUT_POLLS` consecutive polls, the whole dump is aborted with an error pulse.

With the default parameters the interval is 100 cycles, which is 1 µs at 100 MHz, and the limit is one million polls. A testbench can shorten both.

Top module: `fuse_dump_seq`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `err_o`, `grant_o`, `ctl_wr_o` and `buf_we_o` are all low. While idle, no launch and no buffer write occur.
- R2: A dump launches addresses 0, 1, …, `PHYS_SIZE-1` in increasing order, one `ctl_wr_o` pulse per address. Each buffer write targets the most recently launched address.
- R3: Every launched control word has the address in bits 17:8. Bits 7:0 (data field), bit 31 (completion flag) and all other bits are zero.
- R4: A byte is written to the buffer only on a poll that sees `ctl_flag_i` = 1. The written value is `ctl_byte_i` at that poll.
- R5: `ctl_flag_i` is sampled once every `POLL_CYC` cycles after a launch. The first sample falls `POLL_CYC` cycles after the launch cycle. After `TIMEOUT_POLLS` consecutive samples with the flag clear, `err_o` pulses for one cycle. It appears `POLL_CYC*TIMEOUT_POLLS+1` cycles after the launch cycle, and `done_o` does not pulse.
- R6: After an error there are no further buffer writes or launches, and `busy_o` drops.
- R7: After the last byte is written, `done_o` pulses for exactly one cycle. In that cycle `grant_o` is already low. `done_o` and `err_o` are never high together.
- R8: `grant_o` is high from the cycle before the first launch through the last buffer write. Whenever `grant_o` is high, `bank_sel_o` equals `BANK_ID` (default 0).
- R9: A `start_i` pulse while `busy_o` is high is ignored. The running dump completes with exactly `PHYS_SIZE` writes in order and one `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a dump (used only when idle) |
| busy_o | output | 1 | Dump in progress |
| done_o | output | 1 | One-cycle pulse: dump completed |
| err_o | output | 1 | One-cycle pulse: dump aborted on poll timeout |
| grant_o | output | 1 | Fuse access held |
| bank_sel_o | output | BANK_W | Fuse bank select |
| ctl_wr_o | output | 1 | Control-word write strobe (launches a read) |
| ctl_wdata_o | output | 32 | Control word: address at 17:8, flag bit 31 clear |
| ctl_flag_i | input | 1 | Readback completion flag (control word bit 31) |
| ctl_byte_i | input | 8 | Readback data byte (control word bits 7:0) |
| buf_we_o | output | 1 | Buffer byte write enable |
| buf_addr_o | output | $clog2(PHYS_SIZE) | Buffer byte address |
| buf_data_o | output | 8 | Buffer byte data |

## Verification
The bench model of the fuse macro keeps its flag set from the previous read and returns a stale byte until it clears the flag on a launch. A sequencer that samples before its first poll interval, or that treats a leftover flag as completion, would write stale or wrong bytes. Macro latencies of 1, 6 and 13 cycles check that the write lands on the first poll after the data becomes valid. A sequencer with an off-by-one poll divider would show a shifted write cycle.

Stuck reads at the first, a middle and the last address check the exact timeout cycle and the write count. A miscounted limit would show up in the cycle count. A sequencer that kept going after the abort would show extra writes or launches. A second start in the middle of a dump checks that the address walk is not restarted.

// File: rtl/fuse_dump_pkg.sv
package fuse_dump_pkg;
  // Control word layout seen by the fuse macro
  localparam int CTL_W        = 32;
  localparam int CTL_FLAG_BIT = 31;
  localparam int CTL_ADDR_LSB = 8;
  localparam int CTL_ADDR_W   = 10;
  localparam int BYTE_W       = 8;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_GRANT  = 3'd1,
    S_LAUNCH = 3'd2,
    S_WAIT   = 3'd3,
    S_DONE   = 3'd4,
    S_ERR    = 3'd5
  } dump_state_t;
endpackage

// File: rtl/fuse_poll_timer.sv
module fuse_poll_timer #(
  parameter int POLL_CYC      = 100,
  parameter int TIMEOUT_POLLS = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  input  logic flag_i,
  output logic poll_o,
  output logic timeout_o
);
  localparam int DIV_W = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int CNT_W = $clog2(TIMEOUT_POLLS + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(POLL_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_POLLS - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_en, cnt_en;

  assign poll_o    = run_i && (div_q == DIV_LAST);
  assign timeout_o = poll_o && !flag_i && (cnt_q == CNT_LAST);

  always_comb begin
    div_en = clear_i || run_i;
    div_d  = (clear_i || poll_o) ? '0 : div_q + 1'b1;
    cnt_en = clear_i || (poll_o && !flag_i);
    cnt_d  = clear_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      if (div_en) div_q <= div_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/fuse_addr_ctr.sv
module fuse_addr_ctr #(
  parameter int AW   = 9,
  parameter int LAST = 511
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = clr_i || inc_i;
    addr_d  = clr_i ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == AW'(LAST));
endmodule

// File: rtl/fuse_dump_seq.sv
module fuse_dump_seq
  import fuse_dump_pkg::*;
#(
  parameter int PHYS_SIZE     = 512,
  parameter int POLL_CYC      = 100,
  parameter int TIMEOUT_POLLS = 1000000,
  parameter int BANK_W        = 2,
  parameter int BANK_ID       = 0,
  localparam int AW           = $clog2(PHYS_SIZE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              grant_o,
  output logic [BANK_W-1:0] bank_sel_o,
  output logic              ctl_wr_o,
  output logic [CTL_W-1:0]  ctl_wdata_o,
  input  logic              ctl_flag_i,
  input  logic [BYTE_W-1:0] ctl_byte_i,
  output logic              buf_we_o,
  output logic [AW-1:0]     buf_addr_o,
  output logic [BYTE_W-1:0] buf_data_o
);
  dump_state_t       state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic              bank_en;
  logic [AW-1:0]     addr;
  logic              addr_last, addr_clr, addr_inc;
  logic              poll, timeout, got_byte;

  fuse_addr_ctr #(.AW(AW), .LAST(PHYS_SIZE - 1)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (addr_clr),
    .inc_i  (addr_inc),
    .addr_o (addr),
    .last_o (addr_last)
  );

  fuse_poll_timer #(.POLL_CYC(POLL_CYC), .TIMEOUT_POLLS(TIMEOUT_POLLS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (state_q == S_LAUNCH),
    .run_i     (state_q == S_WAIT),
    .flag_i    (ctl_flag_i),
    .poll_o    (poll),
    .timeout_o (timeout)
  );

  assign got_byte = (state_q == S_WAIT) && poll && ctl_flag_i;

  // Next-state
  always_comb begin
    state_d  = state_q;
    addr_clr = 1'b0;
    addr_inc = 1'b0;
    bank_en  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d  = S_GRANT;
        addr_clr = 1'b1;
        bank_en  = 1'b1;
      end
      S_GRANT:  state_d = S_LAUNCH;
      S_LAUNCH: state_d = S_WAIT;
      S_WAIT: begin
        if (got_byte) begin
          if (addr_last) state_d = S_DONE;
          else begin
            state_d  = S_LAUNCH;
            addr_inc = 1'b1;
          end
        end else if (timeout) begin
          state_d = S_ERR;
        end
      end
      S_DONE:  state_d = S_IDLE;
      S_ERR:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      bank_q  <= '0;
    end else begin
      state_q <= state_d;
      if (bank_en) bank_q <= BANK_W'(BANK_ID);
    end
  end

  // Outputs
  always_comb begin
    ctl_wdata_o = '0;
    ctl_wdata_o[CTL_ADDR_LSB +: CTL_ADDR_W] = CTL_ADDR_W'(addr);
  end

  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign err_o      = (state_q == S_ERR);
  assign grant_o    = (state_q == S_GRANT) || (state_q == S_LAUNCH) || (state_q == S_WAIT);
  assign bank_sel_o = bank_q;
  assign ctl_wr_o   = (state_q == S_LAUNCH);
  assign buf_we_o   = got_byte;
  assign buf_addr_o = addr;
  assign buf_data_o = ctl_byte_i;
endmodule

// File: rtl/fuse_dump_seq_chk.sv
module fuse_dump_seq_chk #(
  parameter int PHYS_SIZE = 512,
  parameter int BANK_W    = 2,
  parameter int BANK_ID   = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              grant_o,
  input logic [BANK_W-1:0] bank_sel_o,
  input logic              ctl_wr_o,
  input logic [31:0]       ctl_wdata_o,
  input logic              ctl_flag_i,
  input logic              buf_we_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!buf_we_o && !ctl_wr_o && !grant_o));

  p_word_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_o |-> (ctl_wdata_o[31] == 1'b0 && ctl_wdata_o[7:0] == 8'h00));

  p_write_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we_o |-> ctl_flag_i);

  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (!err_o && !busy_o));

  p_quiet_after_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (!buf_we_o && !ctl_wr_o));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_launch_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_o |-> (grant_o && bank_sel_o == BANK_W'(BANK_ID)));

  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && !err_o) |=> busy_o);
endmodule

bind fuse_dump_seq fuse_dump_seq_chk #(
  .PHYS_SIZE (PHYS_SIZE),
  .BANK_W    (BANK_W),
  .BANK_ID   (BANK_ID)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .grant_o     (grant_o),
  .bank_sel_o  (bank_sel_o),
  .ctl_wr_o    (ctl_wr_o),
  .ctl_wdata_o (ctl_wdata_o),
  .ctl_flag_i  (ctl_flag_i),
  .buf_we_o    (buf_we_o)
);

// File: tb/test_fuse_dump_seq.sv
module test_fuse_dump_seq;
  localparam int PHYS = 8;
  localparam int PC   = 4;
  localparam int TO   = 5;
  localparam int AW   = $clog2(PHYS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, err_o, grant_o, ctl_wr_o, buf_we_o;
  logic [1:0] bank_sel_o;
  logic [31:0] ctl_wdata_o;
  logic ctl_flag_i;
  logic [7:0] ctl_byte_i, buf_data_o;
  logic [AW-1:0] buf_addr_o;

  always #5 clk = ~clk;

  fuse_dump_seq #(.PHYS_SIZE(PHYS), .POLL_CYC(PC), .TIMEOUT_POLLS(TO),
                  .BANK_W(2), .BANK_ID(0)) i_fuse_dump_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .grant_o(grant_o), .bank_sel_o(bank_sel_o),
    .ctl_wr_o(ctl_wr_o), .ctl_wdata_o(ctl_wdata_o), .ctl_flag_i(ctl_flag_i),
    .ctl_byte_i(ctl_byte_i), .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o),
    .buf_data_o(buf_data_o));

  int n_chk = 0, n_err = 0;
  int cur_lat = 1, stuck_en = 0, stuck_addr = 0, seed = 0;
  int cyc = 0, last_launch = 0;
  int exp_next = 0, wr_cnt = 0, launch_cnt = 0, done_cnt = 0, err_cnt = 0;
  bit finished = 0;

  function automatic logic [7:0] fdat(int a, int s);
    return 8'(((a * 29) + s) ^ 8'hA5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Fuse macro model: flag cleared by a launch, set after cur_lat edges
  logic [9:0] m_addr;
  int m_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_flag_i <= 1'b1;
      ctl_byte_i <= 8'hEE;
      m_addr <= '0;
      m_cnt <= 0;
    end else if (ctl_wr_o) begin
      ctl_flag_i <= 1'b0;
      ctl_byte_i <= 8'hEE;
      m_addr <= ctl_wdata_o[17:8];
      m_cnt <= cur_lat;
    end else if (!ctl_flag_i && m_cnt != 0) begin
      m_cnt <= m_cnt - 1;
      if (m_cnt == 1 && !(stuck_en != 0 && int'(m_addr) == stuck_addr)) begin
        ctl_flag_i <= 1'b1;
        ctl_byte_i <= fdat(int'(m_addr), seed);
      end
    end
  end

  // Monitor sampling at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (start_i && !busy_o) begin
        exp_next = 0; wr_cnt = 0; launch_cnt = 0; done_cnt = 0; err_cnt = 0;
      end
      if (ctl_wr_o) begin
        chk(ctl_wdata_o[17:8] == 10'(exp_next), "R2 launch address", int'(ctl_wdata_o[17:8]), exp_next);
        chk(ctl_wdata_o[31] == 1'b0 && ctl_wdata_o[7:0] == 8'h00 && ctl_wdata_o[30:18] == '0,
            "R3 control word", int'(ctl_wdata_o), exp_next << 8);
        chk(grant_o && bank_sel_o == 2'd0, "R8 grant/bank at launch", int'({grant_o, bank_sel_o}), 4);
        last_launch = cyc;
        launch_cnt++;
      end
      if (buf_we_o) begin
        chk(int'(buf_addr_o) == exp_next, "R2 write address order", int'(buf_addr_o), exp_next);
        chk(buf_data_o == fdat(exp_next, seed), "R4 written byte", int'(buf_data_o), int'(fdat(exp_next, seed)));
        chk(cyc - last_launch == PC * ((cur_lat + PC) / PC), "R5 write poll timing",
            cyc - last_launch, PC * ((cur_lat + PC) / PC));
        chk(grant_o, "R8 grant at write", int'(grant_o), 1);
        wr_cnt++;
        exp_next++;
      end
      if (err_o) begin
        chk(cyc - last_launch == PC * TO + 1, "R5 timeout cycle", cyc - last_launch, PC * TO + 1);
        err_cnt++;
      end
      if (done_o) begin
        chk(!grant_o, "R7 grant released at done", int'(grant_o), 0);
        done_cnt++;
      end
    end
  end

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done_o || err_o) break;
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  // lat, stuck_en, stuck_addr, seed, expect_err
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{1,  0, 0, 8'h11, 0},
    '{6,  0, 0, 8'h5A, 0},
    '{13, 0, 0, 8'hC3, 0},
    '{3,  1, 3, 8'h27, 1},
    '{2,  1, 0, 8'h99, 1},
    '{4,  1, 7, 8'h42, 1}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !err_o && !grant_o && !ctl_wr_o && !buf_we_o,
        "R1 reset outputs", int'({busy_o, done_o, err_o, grant_o, ctl_wr_o, buf_we_o}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy_o && launch_cnt == 0, "R1 idle after reset", launch_cnt, 0);

    for (int v = 0; v < NV; v++) begin
      cur_lat = VEC[v][0]; stuck_en = VEC[v][1]; stuck_addr = VEC[v][2];
      seed = VEC[v][3];
      pulse_start();
      wait_end();
      @(negedge clk);
      chk(!busy_o, "R6/R7 busy drops", int'(busy_o), 0);
      repeat (20) @(negedge clk);
      if (VEC[v][4] != 0) begin
        chk(err_cnt == 1 && done_cnt == 0, "R5 error instead of done", err_cnt * 10 + done_cnt, 10);
        chk(wr_cnt == stuck_addr, "R6 writes before abort", wr_cnt, stuck_addr);
        chk(launch_cnt == stuck_addr + 1, "R6 no launch after abort", launch_cnt, stuck_addr + 1);
      end else begin
        chk(done_cnt == 1 && err_cnt == 0, "R7 single done", done_cnt * 10 + err_cnt, 10);
        chk(wr_cnt == PHYS, "R2 full dump", wr_cnt, PHYS);
      end
    end

    // R9: second start while busy is ignored
    cur_lat = 6; stuck_en = 0; seed = 8'h3C;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(busy_o, "R9 busy mid-dump", int'(busy_o), 1);
    pulse_start();
    wait_end();
    repeat (20) @(negedge clk);
    chk(wr_cnt == PHYS && done_cnt == 1, "R9 start ignored while busy", wr_cnt, PHYS);
    chk(!busy_o && !grant_o, "R8 grant released after dump", int'({busy_o, grant_o}), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule